// File: doc/BRIEF.md
# Debug Program Buffer with Register-Transfer Command Engine

This block holds the scratch memory a debugger uses to steer a stopped hart: a sixteen-word instruction buffer followed directly by one data word, all plain 32-bit RAM. Because the two regions sit back to back at word indexes 0 to 16, either one can carry code or data. A debug transport fills and reads this memory through a small register port. The same port also accepts command words and exposes a status word.

The hart fetches from this memory over the system bus. Such accesses are served only when the requester is in debug mode. Accesses from any other mode, and accesses beyond the last word, are refused with an error flag.

A minimal command engine moves values between the data word and the hart's general-purpose registers. It accepts only register-transfer commands aimed at a halted hart. Any other command is refused and recorded in a sticky three-bit error field.

Top module: `dbgbuf_top`

## Requirements
- R1: Transport word addresses 0 to 15 reach the sixteen instruction-buffer words and address 16 reaches the data word. System-bus indexes 0 to 16 reach the same seventeen words, so a value written through either port reads back unchanged through the other.
- R2: A system-bus request made while `sb_dbg_mode_i` is low raises `sb_err_o` in the same cycle and returns zero read data. A write made this way leaves the memory unchanged.
- R3: A system-bus request to an index of 17 or above raises `sb_err_o` and returns zero read data. A write made this way changes no word.
- R4: A command is a transport write to address 17. Bits [31:24] give the kind, which must be 0. Bit 16 is 1 for a register write and 0 for a register read. Bits [15:0] give the register number, which must lie in 0x1000 to 0x101F and selects GPR (number − 0x1000). Any other command records error code 2 and makes no register-file access. This check takes precedence over the halted check.
- R5: A supported command issued while `hart_halted_i` is low records error code 4 and makes no register-file access.
- R6: An accepted read keeps busy high for exactly the two cycles after the command edge. In the first busy cycle, `rf_req_o` is high, `rf_we_o` is low and `rf_idx_o` carries the GPR index. After busy falls, the data word holds the GPR value.
- R7: An accepted write drives `rf_req_o` and `rf_we_o` high in its first busy cycle only, with `rf_wdata_o` equal to the data word and `rf_idx_o` equal to the GPR index.
- R8: A command issued while busy records error code 1 and is dropped. The running command completes unchanged.
- R9: A new error code is recorded only while the error field is 0; otherwise the field keeps its value. Writing the status address (18) clears each error bit whose matching bit in [2:0] of the written data is 1.
- R10: The status word, read at transport address 18, carries the error field in [2:0] and busy in bit 8. Bits 12 and 13, the reset-status flags, always read 0. After reset the status word is 0.
- R11: When several writes land on the same word in the same cycle, the engine's register-read capture wins over a transport write, and a transport write wins over a system-bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| tp_req_i | input | 1 | Transport access strobe |
| tp_we_i | input | 1 | Transport write enable |
| tp_addr_i | input | 5 | Transport word address (0–16 memory, 17 command, 18 status) |
| tp_wdata_i | input | 32 | Transport write data |
| tp_rdata_o | output | 32 | Transport read data for `tp_addr_i` (combinational) |
| sb_req_i | input | 1 | System-bus access strobe |
| sb_we_i | input | 1 | System-bus write enable |
| sb_addr_i | input | 5 | System-bus word index |
| sb_wdata_i | input | 32 | System-bus write data |
| sb_dbg_mode_i | input | 1 | Requesting hart is in debug mode |
| sb_rdata_o | output | 32 | System-bus read data, zero on a refused access |
| sb_err_o | output | 1 | System-bus access refused |
| hart_halted_i | input | 1 | Hart is halted |
| rf_req_o | output | 1 | Register-file access strobe |
| rf_we_o | output | 1 | Register-file write enable |
| rf_idx_o | output | 5 | GPR index |
| rf_wdata_o | output | 32 | Value written to the GPR |
| rf_rdata_i | input | 32 | GPR value for `rf_idx_o` (combinational) |

## Verification
The data word can receive writes in a single cycle from three places: the engine's capture at the end of a register read, the transport port, and the system bus. The bench lines up all three on the same clock edge. It first issues a register read, waits one cycle, and then drives a transport write and a system-bus write to word 16 so that both land on the capture edge. The word must then hold the GPR value. A separate case writes both ports to one buffer word in the same cycle and expects the transport value.

// File: rtl/dbgbuf_pkg.sv
package dbgbuf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ISSUE,
        PH_FINISH
    } phase_e;

    localparam logic [2:0]  ERR_NONE  = 3'd0;
    localparam logic [2:0]  ERR_BUSY  = 3'd1;
    localparam logic [2:0]  ERR_UNSUP = 3'd2;
    localparam logic [2:0]  ERR_HALT  = 3'd4;

    localparam logic [15:0] GPR_BASE  = 16'h1000;

    localparam int STAT_BUSY_BIT  = 8;

endpackage

// File: rtl/dbgbuf_ram.sv
module dbgbuf_ram #(
    parameter int WORDS  = 17,
    parameter int WORD_W = 32,
    parameter int AAW    = 5,
    parameter int BAW    = 5,
    parameter int DIDX   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              a_we_i,
    input  logic [AAW-1:0]    a_idx_i,
    input  logic [WORD_W-1:0] a_wdata_i,
    output logic [WORD_W-1:0] a_rdata_o,
    input  logic              b_we_i,
    input  logic [BAW-1:0]    b_idx_i,
    input  logic [WORD_W-1:0] b_wdata_i,
    output logic [WORD_W-1:0] b_rdata_o,
    input  logic              c_we_i,
    input  logic [WORD_W-1:0] c_wdata_i,
    output logic [WORD_W-1:0] dword_o
);

    logic [WORD_W-1:0] mem_d [WORDS];
    logic [WORD_W-1:0] mem_q [WORDS];

    // lowest priority first: system bus, then transport, then engine capture
    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < WORDS; i++) begin
            if (b_we_i && b_idx_i == BAW'(i)) mem_d[i] = b_wdata_i;
            if (a_we_i && a_idx_i == AAW'(i)) mem_d[i] = a_wdata_i;
        end
        if (c_we_i) mem_d[DIDX] = c_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q <= '{default: '0};
        else         mem_q <= mem_d;
    end

    always_comb begin
        a_rdata_o = '0;
        b_rdata_o = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (a_idx_i == AAW'(i)) a_rdata_o = mem_q[i];
            if (b_idx_i == BAW'(i)) b_rdata_o = mem_q[i];
        end
    end

    assign dword_o = mem_q[DIDX];

endmodule

// File: rtl/dbgbuf_sbgate.sv
module dbgbuf_sbgate #(
    parameter int WORDS  = 17,
    parameter int WORD_W = 32,
    parameter int BAW    = 5
) (
    input  logic              sb_req_i,
    input  logic              sb_we_i,
    input  logic [BAW-1:0]    sb_addr_i,
    input  logic              sb_dbg_mode_i,
    input  logic [WORD_W-1:0] ram_rdata_i,
    output logic              ram_we_o,
    output logic              sb_err_o,
    output logic [WORD_W-1:0] sb_rdata_o
);

    logic in_range;
    logic allowed;

    always_comb begin
        in_range   = 32'(sb_addr_i) < 32'(WORDS);
        allowed    = sb_req_i && sb_dbg_mode_i && in_range;
        ram_we_o   = allowed && sb_we_i;
        sb_err_o   = sb_req_i && !allowed;
        sb_rdata_o = allowed ? ram_rdata_i : '0;
    end

endmodule

// File: rtl/dbgbuf_cmd.sv
module dbgbuf_cmd
    import dbgbuf_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int NGPR   = 32,
    parameter int RIW    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_kind_i,
    input  logic              cmd_wr_i,
    input  logic [15:0]       cmd_regno_i,
    input  logic              clr_valid_i,
    input  logic [2:0]        clr_mask_i,
    input  logic              halted_i,
    input  logic [WORD_W-1:0] dword_i,
    input  logic [WORD_W-1:0] rf_rdata_i,
    output logic              busy_o,
    output logic [2:0]        err_o,
    output logic              rf_req_o,
    output logic              rf_we_o,
    output logic [RIW-1:0]    rf_idx_o,
    output logic [WORD_W-1:0] rf_wdata_o,
    output logic              cap_we_o,
    output logic [WORD_W-1:0] cap_wdata_o
);

    typedef struct packed {
        phase_e         ph;
        logic           wr;
        logic [RIW-1:0] idx;
        logic [2:0]     err;
    } eng_t;

    eng_t q, d;

    logic [31:0] regno;
    logic        supported;
    logic        busy;
    logic [2:0]  raise;

    always_comb begin
        d         = q;
        busy      = q.ph != PH_IDLE;
        regno     = 32'(cmd_regno_i);
        supported = (cmd_kind_i == 8'd0)
                 && (regno >= 32'(GPR_BASE))
                 && (regno <  32'(GPR_BASE) + 32'(NGPR));
        raise     = ERR_NONE;

        unique case (q.ph)
            PH_ISSUE:  d.ph = PH_FINISH;
            PH_FINISH: d.ph = PH_IDLE;
            default:   d.ph = q.ph;
        endcase

        if (clr_valid_i) d.err = q.err & ~clr_mask_i;

        if (cmd_valid_i) begin
            if (busy)            raise = ERR_BUSY;
            else if (!supported) raise = ERR_UNSUP;
            else if (!halted_i)  raise = ERR_HALT;
            else begin
                d.ph  = PH_ISSUE;
                d.wr  = cmd_wr_i;
                d.idx = RIW'(regno - 32'(GPR_BASE));
            end
        end

        if (raise != ERR_NONE && q.err == ERR_NONE) d.err = raise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{ph: PH_IDLE, wr: 1'b0, idx: '0, err: ERR_NONE};
        else         q <= d;
    end

    assign busy_o      = q.ph != PH_IDLE;
    assign err_o       = q.err;
    assign rf_req_o    = q.ph == PH_ISSUE;
    assign rf_we_o     = (q.ph == PH_ISSUE) && q.wr;
    assign rf_idx_o    = q.idx;
    assign rf_wdata_o  = dword_i;
    assign cap_we_o    = (q.ph == PH_FINISH) && !q.wr;
    assign cap_wdata_o = rf_rdata_i;

endmodule

// File: rtl/dbgbuf_top.sv
module dbgbuf_top
    import dbgbuf_pkg::*;
#(
    parameter int  PBUF_WORDS = 16,
    parameter int  DATA_WORDS = 1,
    parameter int  WORD_W     = 32,
    parameter int  NGPR       = 32,
    localparam int TOTAL      = PBUF_WORDS + DATA_WORDS,
    localparam int TAW        = $clog2(TOTAL + 2),
    localparam int SAW        = $clog2(TOTAL),
    localparam int RIW        = $clog2(NGPR)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tp_req_i,
    input  logic              tp_we_i,
    input  logic [TAW-1:0]    tp_addr_i,
    input  logic [WORD_W-1:0] tp_wdata_i,
    output logic [WORD_W-1:0] tp_rdata_o,
    input  logic              sb_req_i,
    input  logic              sb_we_i,
    input  logic [SAW-1:0]    sb_addr_i,
    input  logic [WORD_W-1:0] sb_wdata_i,
    input  logic              sb_dbg_mode_i,
    output logic [WORD_W-1:0] sb_rdata_o,
    output logic              sb_err_o,
    input  logic              hart_halted_i,
    output logic              rf_req_o,
    output logic              rf_we_o,
    output logic [RIW-1:0]    rf_idx_o,
    output logic [WORD_W-1:0] rf_wdata_o,
    input  logic [WORD_W-1:0] rf_rdata_i
);

    localparam int DATA_IDX  = PBUF_WORDS;
    localparam int CMD_ADDR  = TOTAL;
    localparam int STAT_ADDR = TOTAL + 1;

    logic              tp_mem_hit;
    logic              tp_mem_we;
    logic              cmd_valid;
    logic              clr_valid;
    logic [WORD_W-1:0] tp_mem_rdata;
    logic [WORD_W-1:0] sb_mem_rdata;
    logic              sb_mem_we;
    logic [WORD_W-1:0] dword;
    logic              cap_we;
    logic [WORD_W-1:0] cap_wdata;
    logic              eng_busy;
    logic [2:0]        eng_err;
    logic [WORD_W-1:0] status_word;

    always_comb begin
        tp_mem_hit  = 32'(tp_addr_i) < 32'(TOTAL);
        tp_mem_we   = tp_req_i && tp_we_i && tp_mem_hit;
        cmd_valid   = tp_req_i && tp_we_i && tp_addr_i == TAW'(CMD_ADDR);
        clr_valid   = tp_req_i && tp_we_i && tp_addr_i == TAW'(STAT_ADDR);

        status_word                = '0;
        status_word[2:0]           = eng_err;
        status_word[STAT_BUSY_BIT] = eng_busy;

        if (tp_mem_hit)                       tp_rdata_o = tp_mem_rdata;
        else if (tp_addr_i == TAW'(STAT_ADDR)) tp_rdata_o = status_word;
        else                                  tp_rdata_o = '0;
    end

    dbgbuf_ram #(
        .WORDS  (TOTAL),
        .WORD_W (WORD_W),
        .AAW    (TAW),
        .BAW    (SAW),
        .DIDX   (DATA_IDX)
    ) u_ram (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .a_we_i    (tp_mem_we),
        .a_idx_i   (tp_addr_i),
        .a_wdata_i (tp_wdata_i),
        .a_rdata_o (tp_mem_rdata),
        .b_we_i    (sb_mem_we),
        .b_idx_i   (sb_addr_i),
        .b_wdata_i (sb_wdata_i),
        .b_rdata_o (sb_mem_rdata),
        .c_we_i    (cap_we),
        .c_wdata_i (cap_wdata),
        .dword_o   (dword)
    );

    dbgbuf_sbgate #(
        .WORDS  (TOTAL),
        .WORD_W (WORD_W),
        .BAW    (SAW)
    ) u_gate (
        .sb_req_i      (sb_req_i),
        .sb_we_i       (sb_we_i),
        .sb_addr_i     (sb_addr_i),
        .sb_dbg_mode_i (sb_dbg_mode_i),
        .ram_rdata_i   (sb_mem_rdata),
        .ram_we_o      (sb_mem_we),
        .sb_err_o      (sb_err_o),
        .sb_rdata_o    (sb_rdata_o)
    );

    dbgbuf_cmd #(
        .WORD_W (WORD_W),
        .NGPR   (NGPR),
        .RIW    (RIW)
    ) u_cmd (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid),
        .cmd_kind_i  (tp_wdata_i[31:24]),
        .cmd_wr_i    (tp_wdata_i[16]),
        .cmd_regno_i (tp_wdata_i[15:0]),
        .clr_valid_i (clr_valid),
        .clr_mask_i  (tp_wdata_i[2:0]),
        .halted_i    (hart_halted_i),
        .dword_i     (dword),
        .rf_rdata_i  (rf_rdata_i),
        .busy_o      (eng_busy),
        .err_o       (eng_err),
        .rf_req_o    (rf_req_o),
        .rf_we_o     (rf_we_o),
        .rf_idx_o    (rf_idx_o),
        .rf_wdata_o  (rf_wdata_o),
        .cap_we_o    (cap_we),
        .cap_wdata_o (cap_wdata)
    );

endmodule

// File: rtl/dbgbuf_chk.sv
module dbgbuf_chk #(
    parameter int TOTAL     = 17,
    parameter int TAW       = 5,
    parameter int SAW       = 5,
    parameter int STAT_ADDR = 18
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           sb_req_i,
    input logic [SAW-1:0] sb_addr_i,
    input logic           sb_dbg_mode_i,
    input logic           sb_err_o,
    input logic           tp_req_i,
    input logic           tp_we_i,
    input logic [TAW-1:0] tp_addr_i,
    input logic [1:0]     stat_rst_bits,
    input logic           hart_halted_i,
    input logic           rf_req_o,
    input logic           busy,
    input logic [2:0]     err
);

    logic stat_clr;
    assign stat_clr = tp_req_i && tp_we_i && tp_addr_i == TAW'(STAT_ADDR);

    assert_sb_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sb_req_i && !sb_dbg_mode_i) |-> sb_err_o);

    assert_sb_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sb_req_i && 32'(sb_addr_i) >= 32'(TOTAL)) |-> sb_err_o);

    assert_start_halted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(hart_halted_i));

    assert_first_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |=> (busy && !rf_req_o));

    assert_busy_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && !rf_req_o) |=> !busy);

    assert_req_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_req_o |-> busy);

    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err != 3'd0 && !stat_clr) |=> $stable(err));

    assert_rst_bits_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tp_addr_i == TAW'(STAT_ADDR)) |-> (stat_rst_bits == 2'b00));

endmodule

bind dbgbuf_top dbgbuf_chk #(
    .TOTAL     (TOTAL),
    .TAW       (TAW),
    .SAW       (SAW),
    .STAT_ADDR (TOTAL + 1)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sb_req_i      (sb_req_i),
    .sb_addr_i     (sb_addr_i),
    .sb_dbg_mode_i (sb_dbg_mode_i),
    .sb_err_o      (sb_err_o),
    .tp_req_i      (tp_req_i),
    .tp_we_i       (tp_we_i),
    .tp_addr_i     (tp_addr_i),
    .stat_rst_bits (tp_rdata_o[13:12]),
    .hart_halted_i (hart_halted_i),
    .rf_req_o      (rf_req_o),
    .busy          (eng_busy),
    .err           (eng_err)
);

// File: tb/dbgbuf_top_tb.sv
`timescale 1ns/1ps
module dbgbuf_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tp_req = 0, tp_we = 0;
    logic [4:0]  tp_addr = 0;
    logic [31:0] tp_wdata = 0;
    logic [31:0] tp_rdata;
    logic        sb_req = 0, sb_we = 0, sb_dbg = 0;
    logic [4:0]  sb_addr = 0;
    logic [31:0] sb_wdata = 0;
    logic [31:0] sb_rdata;
    logic        sb_err;
    logic        halted = 1;
    logic        rf_req, rf_we;
    logic [4:0]  rf_idx;
    logic [31:0] rf_wdata, rf_rdata;

    logic [31:0] gpr [32];
    int          errs = 0, checks = 0, rfreq_cnt = 0;

    always #2.5 clk = ~clk;

    dbgbuf_top u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .tp_req_i(tp_req), .tp_we_i(tp_we), .tp_addr_i(tp_addr),
        .tp_wdata_i(tp_wdata), .tp_rdata_o(tp_rdata),
        .sb_req_i(sb_req), .sb_we_i(sb_we), .sb_addr_i(sb_addr),
        .sb_wdata_i(sb_wdata), .sb_dbg_mode_i(sb_dbg),
        .sb_rdata_o(sb_rdata), .sb_err_o(sb_err),
        .hart_halted_i(halted),
        .rf_req_o(rf_req), .rf_we_o(rf_we), .rf_idx_o(rf_idx),
        .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata)
    );

    function automatic logic [31:0] gval(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0101;
    endfunction

    // hart register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) gpr[i] <= gval(i);
        end else begin
            if (rf_req && rf_we) gpr[rf_idx] <= rf_wdata;
            if (rf_req) rfreq_cnt <= rfreq_cnt + 1;
        end
    end
    assign rf_rdata = gpr[rf_idx];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tp_wr(logic [4:0] a, logic [31:0] v);
        @(negedge clk);
        tp_req = 1; tp_we = 1; tp_addr = a; tp_wdata = v;
        @(negedge clk);
        tp_req = 0; tp_we = 0;
    endtask

    task automatic tp_rd(logic [4:0] a, output logic [31:0] v);
        tp_addr = a;
        #1;
        v = tp_rdata;
    endtask

    task automatic sb_acc(logic we, logic [4:0] a, logic [31:0] v, logic dbg,
                          output logic e, output logic [31:0] r);
        @(negedge clk);
        sb_req = 1; sb_we = we; sb_addr = a; sb_wdata = v; sb_dbg = dbg;
        #1;
        e = sb_err; r = sb_rdata;
        @(negedge clk);
        sb_req = 0; sb_we = 0;
    endtask

    task automatic run_cmd(logic [31:0] c);
        tp_wr(5'd17, c);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic        e;
        int          c0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        tp_rd(5'd18, v); chk("R10 status after reset", v, 32'h0);
        tp_rd(5'd16, v); chk("R1 data word after reset", v, 32'h0);
        chk("R6 rf_req idle after reset", 32'(rf_req), 32'h0);

        // R1 transport writes, system-bus reads
        for (int i = 0; i < 17; i++) tp_wr(5'(i), 32'h1111_0000 + 32'(i) * 32'h31);
        for (int i = 0; i < 17; i++) begin
            sb_acc(1'b0, 5'(i), 32'h0, 1'b1, e, v);
            chk("R1 sb read of tp data", v, 32'h1111_0000 + 32'(i) * 32'h31);
            chk("R1 sb err on legal read", 32'(e), 32'h0);
        end
        // R1 system-bus writes, transport reads
        for (int i = 0; i < 17; i++) sb_acc(1'b1, 5'(i), 32'h7700_0000 ^ (32'(i) << 8), 1'b1, e, v);
        for (int i = 0; i < 17; i++) begin
            tp_rd(5'(i), v);
            chk("R1 tp read of sb data", v, 32'h7700_0000 ^ (32'(i) << 8));
        end

        // R2 outside debug mode
        sb_acc(1'b1, 5'd4, 32'hDEAD_BEEF, 1'b0, e, v);
        chk("R2 err outside debug mode", 32'(e), 32'h1);
        chk("R2 rdata zero", v, 32'h0);
        tp_rd(5'd4, v); chk("R2 word unchanged", v, 32'h7700_0000 ^ (32'd4 << 8));

        // R3 out of range
        sb_acc(1'b1, 5'd17, 32'hDEAD_BEEF, 1'b1, e, v);
        chk("R3 err index 17", 32'(e), 32'h1);
        chk("R3 rdata zero", v, 32'h0);
        sb_acc(1'b1, 5'd31, 32'hDEAD_BEEF, 1'b1, e, v);
        chk("R3 err index 31", 32'(e), 32'h1);
        for (int i = 0; i < 17; i++) begin
            tp_rd(5'(i), v);
            chk("R3 no word changed", v, 32'h7700_0000 ^ (32'(i) << 8));
        end

        // R11 transport beats system bus on the same word
        @(negedge clk);
        tp_req = 1; tp_we = 1; tp_addr = 5'd9; tp_wdata = 32'hAAAA_0009;
        sb_req = 1; sb_we = 1; sb_addr = 5'd9; sb_wdata = 32'hBBBB_0009; sb_dbg = 1;
        @(negedge clk);
        tp_req = 0; tp_we = 0; sb_req = 0; sb_we = 0;
        tp_rd(5'd9, v); chk("R11 tp over sb", v, 32'hAAAA_0009);

        // R6 read timing
        tp_wr(5'd17, 32'h0000_1005);
        chk("R6 rf_req first busy cycle", 32'(rf_req), 32'h1);
        chk("R6 rf_we low for read", 32'(rf_we), 32'h0);
        chk("R6 rf_idx", 32'(rf_idx), 32'd5);
        tp_rd(5'd18, v); chk("R10 busy bit set", v, 32'h100);
        @(negedge clk);
        chk("R6 rf_req second cycle", 32'(rf_req), 32'h0);
        tp_rd(5'd18, v); chk("R6 busy second cycle", v, 32'h100);
        @(negedge clk);
        tp_rd(5'd18, v); chk("R6 busy done", v, 32'h0);
        tp_rd(5'd16, v); chk("R6 data word after read", v, gval(5));

        // R6 sweep of every GPR
        for (int i = 0; i < 32; i++) begin
            run_cmd(32'h0000_1000 + 32'(i));
            tp_rd(5'd16, v);
            chk("R6 read sweep", v, gval(i));
        end

        // R11 capture beats transport and system bus
        tp_wr(5'd17, 32'h0000_100A);
        @(negedge clk);
        tp_req = 1; tp_we = 1; tp_addr = 5'd16; tp_wdata = 32'hAAAA_AAAA;
        sb_req = 1; sb_we = 1; sb_addr = 5'd16; sb_wdata = 32'hBBBB_BBBB; sb_dbg = 1;
        @(negedge clk);
        tp_req = 0; tp_we = 0; sb_req = 0; sb_we = 0;
        tp_rd(5'd16, v); chk("R11 capture wins", v, gval(10));

        // R8 command while busy
        tp_wr(5'd17, 32'h0000_1007);
        tp_wr(5'd17, 32'h0000_1008);
        @(negedge clk);
        tp_rd(5'd18, v); chk("R8 busy error code", v, 32'h1);
        tp_rd(5'd16, v); chk("R8 first command intact", v, gval(7));
        tp_wr(5'd18, 32'h7);
        tp_rd(5'd18, v); chk("R9 clear", v, 32'h0);

        // R4 unsupported commands
        begin
            logic [31:0] bad [4];
            bad[0] = 32'h0000_0FFF; bad[1] = 32'h0000_1020;
            bad[2] = 32'h0000_0000; bad[3] = 32'h0100_1000;
            for (int k = 0; k < 4; k++) begin
                c0 = rfreq_cnt;
                run_cmd(bad[k]);
                tp_rd(5'd18, v); chk("R4 unsupported code", v, 32'h2);
                chk("R4 no rf access", 32'(rfreq_cnt), 32'(c0));
                tp_wr(5'd18, 32'h7);
            end
        end

        // R5 hart not halted
        halted = 0;
        c0 = rfreq_cnt;
        run_cmd(32'h0000_1002);
        tp_rd(5'd18, v); chk("R5 not halted code", v, 32'h4);
        chk("R5 no rf access", 32'(rfreq_cnt), 32'(c0));
        // R9 sticky
        run_cmd(32'h0000_1020);
        tp_rd(5'd18, v); chk("R9 sticky keeps first", v, 32'h4);
        tp_wr(5'd18, 32'h3);
        tp_rd(5'd18, v); chk("R9 partial clear", v, 32'h4);
        tp_wr(5'd18, 32'h4);
        tp_rd(5'd18, v); chk("R9 clear bit", v, 32'h0);
        // R4 precedence over not-halted
        run_cmd(32'h0000_2000);
        tp_rd(5'd18, v); chk("R4 precedence", v, 32'h2);
        tp_wr(5'd18, 32'h7);
        halted = 1;

        // R7 write timing
        tp_wr(5'd16, 32'hC0DE_0003);
        tp_wr(5'd17, 32'h0001_1003);
        chk("R7 rf_req", 32'(rf_req), 32'h1);
        chk("R7 rf_we", 32'(rf_we), 32'h1);
        chk("R7 rf_wdata", rf_wdata, 32'hC0DE_0003);
        chk("R7 rf_idx", 32'(rf_idx), 32'd3);
        @(negedge clk);
        chk("R7 rf_req one cycle", 32'(rf_req), 32'h0);
        @(negedge clk);
        chk("R7 gpr written", gpr[3], 32'hC0DE_0003);

        // R7 sweep of every GPR
        for (int i = 0; i < 32; i++) begin
            tp_wr(5'd16, 32'h5A00_0000 ^ (32'(i) * 32'h1111));
            run_cmd(32'h0001_1000 + 32'(i));
            chk("R7 write sweep", gpr[i], 32'h5A00_0000 ^ (32'(i) * 32'h1111));
        end
        tp_rd(5'd18, v); chk("R10 final status", v, 32'h0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule